// File: doc/BRIEF.md
# Supply recharge history monitor

This block observes the periodic recharge events of a regulated supply while the system is asleep. Each time a recharge begins, a strobe arrives together with the output of a comparator that tells whether the supply is still above its OK threshold at that moment. The block records the most recent comparator samples in a short shift history. This lets software see at a glance whether recent recharges were started in time.

Between recharge starts the block counts periods of the low-frequency clock, which arrive as single-cycle tick pulses. When a recharge begins and the supply was still OK, the elapsed interval is a safe interval. The block keeps the largest such safe interval seen since the peak was last cleared. That value indicates how much standby leakage the supply can tolerate. Any write to the status register clears the peak. The algorithm that decides when to recharge is outside this block.

Top module: `rchg_monitor`

## Requirements
- R1: After reset, the history output `hist_o` and the peak output `peak_o` are both 0.
- R2: On a cycle with `rchg_start` high, `hist_o` shifts left by one bit on the next clock edge, and bit 0 takes `vdd_ok`, where 1 means the supply was above threshold and 0 means it was below.
- R3: `hist_o` does not change on cycles without `rchg_start`. Ticks and status writes leave it unchanged.
- R4: The interval is the number of cycles with `lf_tick` high that fall strictly between two consecutive `rchg_start` cycles. A tick in the same cycle as a start is not counted. The count restarts at 0 after each start has been evaluated.
- R5: At a start with `vdd_ok` = 1 and a previous start to measure from, `peak_o` takes the interval if the interval is strictly larger than the current `peak_o`. Otherwise `peak_o` keeps its value.
- R6: At a start with `vdd_ok` = 0, `peak_o` keeps its value, whatever the interval.
- R7: The first start after reset, and the first start after a status write, is not evaluated and leaves `peak_o` unchanged. That start serves as the reference for the next one.
- R8: A cycle with `stat_wr` high clears `peak_o` to 0 on the next edge. If a start coincides with the write, the write wins, no evaluation takes place, and that start becomes the new reference.
- R9: The interval saturates at 0xFFFF instead of wrapping, so a very long safe interval is reported as 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lf_tick | input | 1 | One-cycle pulse per low-frequency clock period |
| rchg_start | input | 1 | One-cycle strobe marking the start of a recharge |
| vdd_ok | input | 1 | Comparator output: 1 when the supply is above its OK threshold |
| stat_wr | input | 1 | Status register write strobe; clears the peak |
| hist_o | output | 4 | Shift history of the last comparator samples, newest in bit 0 |
| peak_o | output | 16 | Largest interval, in ticks, after which the supply was still OK |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- **Unarmed first start:** a design that evaluated the first start after reset or after a clear would load a stale count into the peak.
- **Equal and smaller intervals, and low-comparator starts:** a design using greater-or-equal, or ignoring the comparator, would change the peak when it should hold.
- **Tick coincident with a start:** a design that counted this tick would report the interval one too high.
- **Write coincident with a start:** a design that failed to arm the reference on that start would skip the following interval.
- **Run past the 16-bit range:** a wrapping counter would report a small value instead of 0xFFFF.

// File: rtl/rchg_pkg.sv
package rchg_pkg;
  localparam int unsigned RCHG_HIST_W_DEF = 4;
  localparam int unsigned RCHG_CNT_W_DEF  = 16;
endpackage

// File: rtl/rchg_rst_sync.sv
module rchg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rchg_hist_shift.sv
module rchg_hist_shift #(
  parameter int unsigned HIST_W = rchg_pkg::RCHG_HIST_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              ok_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;

  // Each history bit takes its lower neighbour (bit 0 takes the sample) on a start.
  for (genvar i = 0; i < HIST_W; i++) begin : g_bit
    logic shift_in;
    if (i == 0) begin : g_lsb
      assign shift_in = ok_i;
    end else begin : g_upper
      assign shift_in = hist_q[i-1];
    end
    always_comb begin
      hist_d[i] = hist_q[i];
      if (start_i) hist_d[i] = shift_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hist_q <= '0;
    else if (start_i) hist_q <= hist_d;
  end

  assign hist_o = hist_q;

  assert_hist_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(hist_o));
  assert_hist_newest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (hist_o[0] == $past(ok_i)));
endmodule

// File: rtl/rchg_interval_cnt.sv
module rchg_interval_cnt #(
  parameter int unsigned CNT_W = rchg_pkg::RCHG_CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             armed_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)                        cnt_d = '0;
    else if (tick_i && cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
  end

  assign cnt_en = start_i | tick_i;

  always_comb begin
    armed_d = armed_q;
    if (start_i)    armed_d = 1'b1;
    else if (clr_i) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign cnt_o   = cnt_q;
  assign armed_o = armed_q;

  assert_cnt_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (cnt_o == '0));
  assert_cnt_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == CNT_MAX && !start_i) |=> (cnt_o == CNT_MAX));
  assert_cnt_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !tick_i) |=> $stable(cnt_o));
endmodule

// File: rtl/rchg_peak_track.sv
module rchg_peak_track #(
  parameter int unsigned CNT_W = rchg_pkg::RCHG_CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ok_i,
  input  logic             clr_i,
  input  logic             armed_i,
  input  logic [CNT_W-1:0] interval_i,
  output logic [CNT_W-1:0] peak_o
);
  logic [CNT_W-1:0] peak_q, peak_d;
  logic             take;
  logic             peak_en;

  assign take    = start_i & armed_i & ok_i & (interval_i > peak_q);
  assign peak_en = clr_i | take;

  always_comb begin
    peak_d = peak_q;
    if (clr_i)     peak_d = '0;
    else if (take) peak_d = interval_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       peak_q <= '0;
    else if (peak_en) peak_q <= peak_d;
  end

  assign peak_o = peak_q;

  assert_peak_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (peak_o == '0));
  assert_peak_monotonic_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (peak_o >= $past(peak_o)));
  assert_peak_low_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !ok_i && !clr_i) |=> $stable(peak_o));
  assert_peak_unarmed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !armed_i && !clr_i) |=> $stable(peak_o));
  assert_peak_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !clr_i) |=> $stable(peak_o));
endmodule

// File: rtl/rchg_monitor.sv
module rchg_monitor #(
  parameter int unsigned HIST_W = rchg_pkg::RCHG_HIST_W_DEF,
  parameter int unsigned CNT_W  = rchg_pkg::RCHG_CNT_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lf_tick,
  input  logic              rchg_start,
  input  logic              vdd_ok,
  input  logic              stat_wr,
  output logic [HIST_W-1:0] hist_o,
  output logic [CNT_W-1:0]  peak_o
);
  logic             rst_sync_n;
  logic [CNT_W-1:0] interval;
  logic             armed;

  rchg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rchg_hist_shift #(.HIST_W(HIST_W)) u_hist (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (rchg_start),
    .ok_i    (vdd_ok),
    .hist_o  (hist_o)
  );

  rchg_interval_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick_i  (lf_tick),
    .start_i (rchg_start),
    .clr_i   (stat_wr),
    .cnt_o   (interval),
    .armed_o (armed)
  );

  rchg_peak_track #(.CNT_W(CNT_W)) u_peak (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (rchg_start),
    .ok_i       (vdd_ok),
    .clr_i      (stat_wr),
    .armed_i    (armed),
    .interval_i (interval),
    .peak_o     (peak_o)
  );

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_sync_n |=> (hist_o == '0 && peak_o == '0));
endmodule

// File: tb/tb_rchg_monitor.sv
`timescale 1ns/1ps
module tb_rchg_monitor;
  logic        clk;
  logic        rst_n;
  logic        lf_tick;
  logic        rchg_start;
  logic        vdd_ok;
  logic        stat_wr;
  logic [3:0]  hist_o;
  logic [15:0] peak_o;

  int n_checks;
  int n_fail;

  rchg_monitor dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .lf_tick    (lf_tick),
    .rchg_start (rchg_start),
    .vdd_ok     (vdd_ok),
    .stat_wr    (stat_wr),
    .hist_o     (hist_o),
    .peak_o     (peak_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Hold lf_tick high for n cycles, then drop it.
  task automatic ticks(input int n);
    @(negedge clk);
    lf_tick = 1'b1;
    repeat (n) @(negedge clk);
    lf_tick = 1'b0;
  endtask

  // One-cycle recharge start; outputs are settled at the following negedge.
  task automatic start(input logic ok, input logic with_tick, input logic with_wr);
    @(negedge clk);
    rchg_start = 1'b1;
    vdd_ok     = ok;
    lf_tick    = with_tick;
    stat_wr    = with_wr;
    @(negedge clk);
    rchg_start = 1'b0;
    lf_tick    = 1'b0;
    stat_wr    = 1'b0;
    vdd_ok     = 1'b0;
  endtask

  task automatic write_stat();
    @(negedge clk);
    stat_wr = 1'b1;
    @(negedge clk);
    stat_wr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "hist after reset", hist_o, 0);
    check("R1", "peak after reset", peak_o, 0);
  endtask

  task automatic t_first_start();
    ticks(5);
    start(1'b1, 1'b0, 1'b0);
    check("R2", "hist first sample", hist_o, 4'b0001);
    check("R7", "first start not evaluated", peak_o, 0);
  endtask

  task automatic t_growth();
    ticks(10);
    start(1'b1, 1'b0, 1'b0);
    check("R5", "peak takes 10", peak_o, 10);
    check("R2", "hist shift", hist_o, 4'b0011);
    ticks(7);
    start(1'b1, 1'b0, 1'b0);
    check("R5", "smaller kept", peak_o, 10);
    check("R2", "hist shift", hist_o, 4'b0111);
  endtask

  task automatic t_low_and_equal();
    ticks(20);
    start(1'b0, 1'b0, 1'b0);
    check("R6", "low comparator ignored", peak_o, 10);
    check("R2", "hist low sample", hist_o, 4'b1110);
    ticks(10);
    start(1'b1, 1'b0, 1'b0);
    check("R5", "equal interval kept", peak_o, 10);
    check("R2", "hist shift", hist_o, 4'b1101);
  endtask

  task automatic t_coincident_tick();
    ticks(12);
    start(1'b1, 1'b1, 1'b0);
    check("R4", "tick with start not counted", peak_o, 12);
    check("R2", "hist shift", hist_o, 4'b1011);
  endtask

  task automatic t_write_clear();
    ticks(3);
    check("R3", "hist stable over ticks", hist_o, 4'b1011);
    write_stat();
    check("R8", "write clears peak", peak_o, 0);
    check("R3", "write keeps hist", hist_o, 4'b1011);
    ticks(30);
    start(1'b1, 1'b0, 1'b0);
    check("R7", "first start after write", peak_o, 0);
    check("R2", "hist shift", hist_o, 4'b0111);
    ticks(4);
    start(1'b1, 1'b0, 1'b0);
    check("R4", "interval restarted", peak_o, 4);
  endtask

  task automatic t_write_with_start();
    ticks(9);
    start(1'b1, 1'b0, 1'b1);
    check("R8", "write wins over start", peak_o, 0);
    check("R2", "hist shift", hist_o, 4'b1111);
    ticks(2);
    start(1'b1, 1'b0, 1'b0);
    check("R8", "coincident start is reference", peak_o, 2);
  endtask

  task automatic t_saturate();
    ticks(70000);
    start(1'b1, 1'b0, 1'b0);
    check("R9", "saturated interval", peak_o, 16'hFFFF);
    ticks(5);
    start(1'b1, 1'b0, 1'b0);
    check("R5", "small after saturation kept", peak_o, 16'hFFFF);
    write_stat();
    start(1'b0, 1'b0, 1'b0);
    ticks(6);
    start(1'b1, 1'b0, 1'b0);
    check("R4", "count after saturation restart", peak_o, 6);
    check("R2", "hist after mixed", hist_o, 4'b1101);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    n_checks   = 0;
    n_fail     = 0;
    rst_n      = 1'b0;
    lf_tick    = 1'b0;
    rchg_start = 1'b0;
    vdd_ok     = 1'b0;
    stat_wr    = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_first_start();
    t_growth();
    t_low_and_equal();
    t_coincident_tick();
    t_write_clear();
    t_write_with_start();
    t_saturate();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule